// File: doc/BRIEF.md
# Indirect Address Resolution Stage

This pipeline stage sits between instruction decode and execute for instructions that reach their operand through a pointer held in memory. Each instruction arrives with the 15-bit address of its pointer word, a generation number, a flag saying whether the pointer location auto-increments, a flag saying whether the operand must then be loaded, and an opaque tag that is passed through. The stage waits for the memory line that holds the pointer. It extracts the pointer word and, for auto-increment locations, bumps it and writes it back as a single-word masked store. It then joins the current 3-bit data-field value with the 12-bit pointer to form the effective address, issues the operand line read when one is needed, and hands the instruction on to execute.

Squashed work is filtered by generation. The stage keeps a local copy of the generation. An instruction is accepted if its generation equals either that local copy or the global generation, and it is silently dropped otherwise. A restart pulse, or an instruction that carries the newer global generation, makes the local copy adopt the global value. Each of the three outgoing channels (operand load, pointer store, execute) is a one-entry registered slot with a valid/ready handshake. The stage advances only when all three slots can take a new entry.

Top module: `indir_resolve`

## Requirements
- R1: While reset is high, and on the first clock edge after it, `ld_valid_o`, `st_valid_o` and `ex_valid_o` are low. The local generation resets to 0.
- R2: For an accepted instruction, the pointer is word `in_addr_i[2:0]` of the response line (word w at bits `[w*12 +: 12]`). `ex_addr_o` is `{dfield_i, pointer}`, with `dfield_i` sampled in the accepting cycle. `ex_gen_o`, `ex_tag_o` and `ex_load_o` copy the instruction's generation, tag and load flag. All of these appear one cycle after acceptance.
- R3: If no response is present, or `rsp_line_i` differs from `in_addr_i[14:3]`, a non-stale instruction is not accepted (`in_ready_o` low) and no output becomes valid. The stage waits for a matching response.
- R4: For an auto-increment instruction, the pointer used is (word + 1) mod 4096. A store is issued with `st_line_o = in_addr_i[14:3]` and `st_mask_o` equal to 1 shifted left by the word offset. The store data carries the new pointer in that word and zero in every other word.
- R5: A non-auto-increment instruction issues no store and uses the pointer word unchanged.
- R6: When `in_need_load_i` is set, a load with `ld_line_o = ex_addr_o[14:3]` is issued together with the execute entry. Otherwise no load is issued.
- R7: An instruction whose generation matches neither the local nor the global generation is consumed (`in_ready_o` high) and produces no output, whether or not a response is present.
- R8: When an instruction that matches only the global generation is presented with all ports able to accept, the local generation takes the global value. This happens even if the response does not match.
- R9: A `restart_i` pulse sets the local generation to the global generation. An instruction presented in the same cycle is judged against the new value.
- R10: No instruction is consumed while any output slot is valid and its ready is low. A held output keeps its valid and contents until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Pipeline restart pulse |
| glob_gen_i | input | GEN_W | Current global generation |
| dfield_i | input | DF_W | Data-field value from the execute flags |
| in_valid_i | input | 1 | Instruction present |
| in_ready_o | output | 1 | Instruction consumed this cycle |
| in_gen_i | input | GEN_W | Instruction generation |
| in_addr_i | input | ADDR_W | Address of the pointer word |
| in_autoinc_i | input | 1 | Pointer location auto-increments |
| in_need_load_i | input | 1 | Operand load required |
| in_tag_i | input | TAG_W | Pass-through payload |
| rsp_valid_i | input | 1 | Memory line response present |
| rsp_line_i | input | LINE_AW | Line address of the response |
| rsp_data_i | input | LINE_WORDS*WORD_W | Response line words |
| ld_valid_o | output | 1 | Operand load command valid |
| ld_ready_i | input | 1 | Load command taken |
| ld_line_o | output | LINE_AW | Operand line address |
| st_valid_o | output | 1 | Pointer store command valid |
| st_ready_i | input | 1 | Store command taken |
| st_line_o | output | LINE_AW | Store line address |
| st_data_o | output | LINE_WORDS*WORD_W | Store line data |
| st_mask_o | output | LINE_WORDS | Per-word write enable |
| ex_valid_o | output | 1 | Instruction to execute valid |
| ex_ready_i | input | 1 | Execute took the instruction |
| ex_gen_o | output | GEN_W | Generation of the forwarded instruction |
| ex_addr_o | output | ADDR_W | Effective address |
| ex_load_o | output | 1 | Operand load was issued |
| ex_tag_o | output | TAG_W | Pass-through payload |

## Verification
The hardest state to reach is one where the local and global generations differ, and where an instruction's generation hits only one of them. Only that state shows whether the local copy was adopted. The stimulus moves the global generation without a restart, sends an instruction carrying the new value, and then sends one carrying the old local value, which must now be dropped. It does this both with and without a matching response. Random rounds draw the instruction generation from local, global and unrelated values and mix matching, wrong-line and absent responses. Directed cases hold the execute ready low to test backpressure.

// File: rtl/indir_pkg.sv
package indir_pkg;
  typedef enum logic [1:0] {
    GEN_LOCAL  = 2'd0,
    GEN_GLOBAL = 2'd1,
    GEN_STALE  = 2'd2
  } gen_class_e;
endpackage

// File: rtl/indir_gen_filter.sv
module indir_gen_filter
  import indir_pkg::*;
#(
  parameter int GEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [GEN_W-1:0] glob_gen_i,
  input  logic [GEN_W-1:0] in_gen_i,
  input  logic             adopt_i,
  output gen_class_e       cls_o
);
  logic [GEN_W-1:0] loc_q;
  logic [GEN_W-1:0] loc_eff;

  // a restart in this cycle already counts for the instruction presented
  assign loc_eff = restart_i ? glob_gen_i : loc_q;

  always_comb begin
    if (in_gen_i == loc_eff)         cls_o = GEN_LOCAL;
    else if (in_gen_i == glob_gen_i) cls_o = GEN_GLOBAL;
    else                             cls_o = GEN_STALE;
  end

  always_ff @(posedge clk) begin
    if (rst)                        loc_q <= '0;
    else if (restart_i || adopt_i)  loc_q <= glob_gen_i;
  end
endmodule

// File: rtl/indir_line_pick.sv
module indir_line_pick #(
  parameter int LINE_WORDS = 8,
  parameter int WORD_W     = 12,
  localparam int OFF_W     = $clog2(LINE_WORDS)
) (
  input  logic [LINE_WORDS*WORD_W-1:0] line_i,
  input  logic [OFF_W-1:0]             off_i,
  input  logic                         autoinc_i,
  output logic [WORD_W-1:0]            ptr_o,
  output logic [LINE_WORDS*WORD_W-1:0] st_data_o,
  output logic [LINE_WORDS-1:0]        st_mask_o
);
  logic [WORD_W-1:0] raw;

  assign raw   = line_i[off_i*WORD_W +: WORD_W];
  assign ptr_o = autoinc_i ? raw + 1'b1 : raw;  // wraps modulo 2**WORD_W

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    assign st_mask_o[w] = (off_i == OFF_W'(w));
    assign st_data_o[w*WORD_W +: WORD_W] = st_mask_o[w] ? ptr_o : '0;
  end
endmodule

// File: rtl/indir_out_slot.sv
module indir_out_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         can_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  assign can_o = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/indir_resolve.sv
module indir_resolve
  import indir_pkg::*;
#(
  parameter int GEN_W      = 4,
  parameter int DF_W       = 3,
  parameter int WORD_W     = 12,
  parameter int LINE_WORDS = 8,
  parameter int TAG_W      = 8,
  localparam int ADDR_W    = DF_W + WORD_W,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int LINE_AW   = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_WORDS * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart_i,
  input  logic [GEN_W-1:0]   glob_gen_i,
  input  logic [DF_W-1:0]    dfield_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [GEN_W-1:0]   in_gen_i,
  input  logic [ADDR_W-1:0]  in_addr_i,
  input  logic               in_autoinc_i,
  input  logic               in_need_load_i,
  input  logic [TAG_W-1:0]   in_tag_i,
  input  logic               rsp_valid_i,
  input  logic [LINE_AW-1:0] rsp_line_i,
  input  logic [LINE_W-1:0]  rsp_data_i,
  output logic               ld_valid_o,
  input  logic               ld_ready_i,
  output logic [LINE_AW-1:0] ld_line_o,
  output logic               st_valid_o,
  input  logic               st_ready_i,
  output logic [LINE_AW-1:0] st_line_o,
  output logic [LINE_W-1:0]  st_data_o,
  output logic [LINE_WORDS-1:0] st_mask_o,
  output logic               ex_valid_o,
  input  logic               ex_ready_i,
  output logic [GEN_W-1:0]   ex_gen_o,
  output logic [ADDR_W-1:0]  ex_addr_o,
  output logic               ex_load_o,
  output logic [TAG_W-1:0]   ex_tag_o
);
  localparam int ST_W = LINE_AW + LINE_W + LINE_WORDS;
  localparam int EX_W = GEN_W + ADDR_W + 1 + TAG_W;

  gen_class_e          cls;
  logic                ld_can, st_can, ex_can;
  logic                go, stale, hit, accept, adopt;
  logic [OFF_W-1:0]    off;
  logic [LINE_AW-1:0]  line;
  logic [WORD_W-1:0]   ptr;
  logic [LINE_W-1:0]   pk_data;
  logic [LINE_WORDS-1:0] pk_mask;
  logic [ADDR_W-1:0]   final_addr;
  logic [ST_W-1:0]     st_bus;
  logic [EX_W-1:0]     ex_bus;

  assign off   = in_addr_i[OFF_W-1:0];
  assign line  = in_addr_i[ADDR_W-1:OFF_W];
  assign go    = in_valid_i && ld_can && st_can && ex_can;
  assign stale = (cls == GEN_STALE);
  assign hit   = rsp_valid_i && (rsp_line_i == line);
  assign accept     = go && !stale && hit;
  assign adopt      = go && (cls == GEN_GLOBAL);
  assign in_ready_o = go && (stale || hit);
  assign final_addr = {dfield_i, ptr};

  indir_gen_filter #(.GEN_W(GEN_W)) u_gen (
    .clk(clk), .rst(rst), .restart_i(restart_i), .glob_gen_i(glob_gen_i),
    .in_gen_i(in_gen_i), .adopt_i(adopt), .cls_o(cls)
  );

  indir_line_pick #(.LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_pick (
    .line_i(rsp_data_i), .off_i(off), .autoinc_i(in_autoinc_i),
    .ptr_o(ptr), .st_data_o(pk_data), .st_mask_o(pk_mask)
  );

  indir_out_slot #(.W(LINE_AW)) u_ld (
    .clk(clk), .rst(rst), .load_i(accept && in_need_load_i),
    .data_i(final_addr[ADDR_W-1:OFF_W]), .can_o(ld_can),
    .valid_o(ld_valid_o), .ready_i(ld_ready_i), .data_o(ld_line_o)
  );

  indir_out_slot #(.W(ST_W)) u_st (
    .clk(clk), .rst(rst), .load_i(accept && in_autoinc_i),
    .data_i({line, pk_data, pk_mask}), .can_o(st_can),
    .valid_o(st_valid_o), .ready_i(st_ready_i), .data_o(st_bus)
  );
  assign {st_line_o, st_data_o, st_mask_o} = st_bus;

  indir_out_slot #(.W(EX_W)) u_ex (
    .clk(clk), .rst(rst), .load_i(accept),
    .data_i({in_gen_i, final_addr, in_need_load_i, in_tag_i}), .can_o(ex_can),
    .valid_o(ex_valid_o), .ready_i(ex_ready_i), .data_o(ex_bus)
  );
  assign {ex_gen_o, ex_addr_o, ex_load_o, ex_tag_o} = ex_bus;
endmodule

// File: rtl/indir_resolve_chk.sv
module indir_resolve_chk #(
  parameter int ADDR_W     = 15,
  parameter int LINE_WORDS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              ld_valid_o,
  input logic              ld_ready_i,
  input logic              st_valid_o,
  input logic              st_ready_i,
  input logic [LINE_WORDS-1:0] st_mask_o,
  input logic              ex_valid_o,
  input logic              ex_ready_i,
  input logic [ADDR_W-1:0] ex_addr_o
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!ld_valid_o && !st_valid_o && !ex_valid_o));

  assert_mask_single_R4: assert property (@(posedge clk) disable iff (rst)
    st_valid_o |-> $onehot(st_mask_o));

  assert_take_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
    in_ready_o |-> in_valid_i);

  assert_no_take_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    in_ready_o |-> ((!ex_valid_o || ex_ready_i) && (!st_valid_o || st_ready_i)
                    && (!ld_valid_o || ld_ready_i)));

  assert_ex_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ex_valid_o && !ex_ready_i) |=> (ex_valid_o && $stable(ex_addr_o)));

  assert_st_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (st_valid_o && !st_ready_i) |=> st_valid_o);
endmodule

bind indir_resolve indir_resolve_chk #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .ld_valid_o(ld_valid_o), .ld_ready_i(ld_ready_i), .st_valid_o(st_valid_o),
  .st_ready_i(st_ready_i), .st_mask_o(st_mask_o), .ex_valid_o(ex_valid_o),
  .ex_ready_i(ex_ready_i), .ex_addr_o(ex_addr_o)
);

// File: tb/indir_resolve_tb.sv
module indir_resolve_tb;
  logic clk = 0, rst = 1;
  logic restart_i = 0;
  logic [3:0] glob_gen_i = 0;
  logic [2:0] dfield_i = 0;
  logic in_valid_i = 0, in_ready_o;
  logic [3:0] in_gen_i = 0;
  logic [14:0] in_addr_i = 0;
  logic in_autoinc_i = 0, in_need_load_i = 0;
  logic [7:0] in_tag_i = 0;
  logic rsp_valid_i = 0;
  logic [11:0] rsp_line_i = 0;
  logic [95:0] rsp_data_i = 0;
  logic ld_valid_o, ld_ready_i = 1;
  logic [11:0] ld_line_o;
  logic st_valid_o, st_ready_i = 1;
  logic [11:0] st_line_o;
  logic [95:0] st_data_o;
  logic [7:0] st_mask_o;
  logic ex_valid_o, ex_ready_i = 1;
  logic [3:0] ex_gen_o;
  logic [14:0] ex_addr_o;
  logic ex_load_o;
  logic [7:0] ex_tag_o;

  int checks = 0, errors = 0;
  logic [3:0] m_loc = 0, m_glob = 0;

  always #4 clk = ~clk;

  indir_resolve u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [95:0] exp_st_data(input logic [2:0] off, input logic [11:0] v);
    logic [95:0] d = '0;
    d[off*12 +: 12] = v;
    return d;
  endfunction

  task automatic set_glob(input logic [3:0] g);
    @(negedge clk);
    glob_gen_i = g; m_glob = g;
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart_i = 1;
    @(posedge clk);
    m_loc = m_glob;
    @(negedge clk);
    restart_i = 0;
  endtask

  // one instruction presented for one cycle, all readies assumed high
  task automatic issue(input logic [3:0] g, input logic [14:0] a, input bit ai, input bit nl,
                       input logic [7:0] t, input bit rv, input logic [11:0] rl,
                       input logic [95:0] rd, input logic [2:0] df, input string req);
    bit stale, hit, acc;
    logic [11:0] ptr;
    logic [14:0] fa;
    stale = (g != m_loc) && (g != m_glob);
    hit   = rv && (rl == a[14:3]);
    acc   = !stale && hit;
    ptr   = rd[a[2:0]*12 +: 12] + (ai ? 12'd1 : 12'd0);
    fa    = {df, ptr};
    @(negedge clk);
    in_valid_i = 1; in_gen_i = g; in_addr_i = a; in_autoinc_i = ai;
    in_need_load_i = nl; in_tag_i = t; rsp_valid_i = rv; rsp_line_i = rl;
    rsp_data_i = rd; dfield_i = df;
    #1;
    chk(in_ready_o == (stale || hit), req, "in_ready", 96'(in_ready_o), 96'(stale || hit));
    @(posedge clk);
    if (!stale && g != m_loc) m_loc = m_glob;
    @(negedge clk);
    in_valid_i = 0; rsp_valid_i = 0;
    #1;
    chk(ex_valid_o == acc, req, "ex_valid", 96'(ex_valid_o), 96'(acc));
    chk(st_valid_o == (acc && ai), acc ? (ai ? "R4" : "R5") : req, "st_valid",
        96'(st_valid_o), 96'(acc && ai));
    chk(ld_valid_o == (acc && nl), "R6", "ld_valid", 96'(ld_valid_o), 96'(acc && nl));
    if (acc) begin
      chk(ex_addr_o == fa, "R2", "ex_addr", 96'(ex_addr_o), 96'(fa));
      chk(ex_gen_o == g && ex_tag_o == t && ex_load_o == nl, "R2", "ex_gen/tag/load",
          96'({ex_gen_o, ex_tag_o, ex_load_o}), 96'({g, t, nl}));
      if (ai) begin
        chk(st_line_o == a[14:3], "R4", "st_line", 96'(st_line_o), 96'(a[14:3]));
        chk(st_mask_o == (8'd1 << a[2:0]), "R4", "st_mask", 96'(st_mask_o), 96'(8'd1 << a[2:0]));
        chk(st_data_o == exp_st_data(a[2:0], ptr), "R4", "st_data", st_data_o,
            exp_st_data(a[2:0], ptr));
      end
      if (nl) chk(ld_line_o == fa[14:3], "R6", "ld_line", 96'(ld_line_o), 96'(fa[14:3]));
    end
  endtask

  function automatic logic [95:0] rnd_line();
    logic [95:0] d;
    for (int w = 0; w < 3; w++) d[w*32 +: 32] = $urandom;
    return d;
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [95:0] ln;
    logic [3:0] keep_addr;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(!ex_valid_o && !st_valid_o && !ld_valid_o, "R1", "valids in reset",
        96'({ex_valid_o, st_valid_o, ld_valid_o}), 96'(0));
    @(negedge clk); rst = 0;
    #1;
    chk(!ex_valid_o && !st_valid_o && !ld_valid_o, "R1", "valids after reset",
        96'({ex_valid_o, st_valid_o, ld_valid_o}), 96'(0));

    // directed: plain, auto-increment wrap at 4095, word 7
    ln = '0; ln[3*12 +: 12] = 12'o1234;
    issue(0, 15'o12343, 0, 1, 8'h11, 1, 15'o12343 >> 3, ln, 3'd5, "R2");
    ln = '0; ln[7*12 +: 12] = 12'hFFF;
    issue(0, 15'o04567, 1, 0, 8'h22, 1, 15'o04567 >> 3, ln, 3'd2, "R4");
    // R3: wrong line and absent response
    issue(0, 15'o00100, 1, 1, 8'h33, 1, 12'o0011, ln, 3'd1, "R3");
    issue(0, 15'o00100, 1, 1, 8'h33, 0, 12'o0010, ln, 3'd1, "R3");
    // R7: stale with matching response is dropped
    issue(9, 15'o00100, 1, 1, 8'h44, 1, 12'o0010, ln, 3'd1, "R7");
    // R8: adopt global, then old local value is stale
    set_glob(2);
    issue(2, 15'o00200, 0, 0, 8'h55, 0, 12'o0000, ln, 3'd0, "R8");
    set_glob(3);
    issue(0, 15'o00200, 0, 0, 8'h56, 1, 12'o0020, ln, 3'd0, "R8");
    issue(2, 15'o00200, 0, 1, 8'h57, 1, 12'o0020, ln, 3'd6, "R8");
    // R9: restart adopts global
    set_glob(7);
    do_restart();
    set_glob(8);
    issue(7, 15'o00300, 1, 1, 8'h66, 1, 12'o0030, ln, 3'd3, "R9");
    issue(2, 15'o00300, 1, 1, 8'h67, 1, 12'o0030, ln, 3'd3, "R9");

    // R10: execute held busy
    ln = '0; ln[1*12 +: 12] = 12'o0777;
    @(negedge clk); ex_ready_i = 0;
    issue(7, 15'o01001, 0, 0, 8'h77, 1, 12'o0100, ln, 3'd4, "R10");
    @(negedge clk);
    in_valid_i = 1; in_gen_i = 7; in_addr_i = 15'o02002; in_autoinc_i = 0;
    in_need_load_i = 0; rsp_valid_i = 1; rsp_line_i = 12'o0200;
    #1;
    chk(in_ready_o == 0, "R10", "in_ready while blocked", 96'(in_ready_o), 96'(0));
    @(negedge clk);
    in_valid_i = 0; rsp_valid_i = 0;
    #1;
    chk(ex_valid_o && ex_addr_o == 15'o40777, "R10", "held ex entry",
        96'({ex_valid_o, ex_addr_o}), 96'({1'b1, 15'o40777}));
    ex_ready_i = 1;
    @(negedge clk); #1;
    chk(!ex_valid_o, "R10", "ex drained", 96'(ex_valid_o), 96'(0));

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] g;
      logic [14:0] a;
      logic [11:0] rl;
      int pick;
      if ($urandom_range(0, 9) == 0) set_glob(4'($urandom));
      if ($urandom_range(0, 19) == 0) do_restart();
      pick = $urandom_range(0, 2);
      g = (pick == 0) ? m_loc : (pick == 1) ? m_glob : 4'($urandom);
      a = 15'($urandom);
      keep_addr = 4'($urandom_range(0, 3));
      rl = (keep_addr != 0) ? a[14:3] : 12'($urandom);
      issue(g, a, 1'($urandom), 1'($urandom), 8'($urandom), $urandom_range(0, 5) != 0,
            rl, rnd_line(), 3'($urandom), (pick == 2) ? "R7" : "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule